// File: doc/BRIEF.md
# Trace Trigger Event Detector

This block sits beside the capture path of a trace sink. It looks for a trigger cause, then counts the data words committed to trace memory after that cause. When the count reaches a programmed value, it raises a single-cycle trigger-event pulse. Downstream logic can use the pulse to stop capture, start a flush, or mark the stream.

There are two kinds of trigger cause. The first is a rising edge on an external trigger pin, sampled with the block clock. The second is a valid incoming trace beat whose 7-bit stream ID is the reserved trigger value. The detector works only while capture is enabled and the sink runs in circular-buffer mode. In both FIFO modes it stays idle. Only the first cause in a capture session arms it, so a session yields at most one event.

Top module: `trig_event_detect`

## Requirements
- R1: A low-to-high transition of `trig_in`, seen between two consecutive clock samples, is a trigger cause. Holding `trig_in` high does not create further causes.
- R2: A cycle where `beat_valid` is 1 and `beat_id` equals 7'h7D is a trigger cause. Any other ID, or any ID while `beat_valid` is 0, is not a cause.
- R3: With a programmed count N greater than 0, `event_o` rises in the cycle after the N-th `mem_wr` cycle that follows the cause cycle. A write in the cause cycle itself is not counted.
- R4: With a programmed count of 0, `event_o` rises in the cycle after the cause cycle.
- R5: The word count advances only on cycles where `mem_wr` is 1. Idle cycles between writes do not advance it.
- R6: `event_o` is high for exactly one cycle per event.
- R7: `mode` encodes 0 = circular buffer, 1 = software-read FIFO, 2 = hardware-read FIFO, 3 = reserved. In any mode other than 0 the detector stays idle and `event_o` stays 0.
- R8: While `rst_n` is low, and after its release until a cause is seen, `event_o` is 0.
- R9: Only the first cause after capture is enabled arms the counter. Later causes, whether during counting or after the event, neither restart the count nor produce another event until `capt_en` has been cleared and set again.
- R10: Clearing `capt_en` returns the detector to idle and discards the armed state and the partial count. Words written after re-enabling produce no event without a fresh cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capt_en | input | 1 | Trace capture enabled |
| mode | input | 2 | Operating mode (0 circular, 1 SW FIFO, 2 HW FIFO, 3 reserved) |
| trig_in | input | 1 | External trigger input |
| beat_valid | input | 1 | Incoming trace beat valid |
| beat_id | input | 7 | Stream ID of the incoming beat |
| mem_wr | input | 1 | One data word committed to trace memory this cycle |
| word_count | input | CNT_W | Words to count after the cause before the event |
| event_o | output | 1 | Single-cycle trigger-event pulse |

## Verification
The assertions check on every cycle that the pulse is one cycle wide and that no event follows a cycle with capture disabled or a FIFO or reserved mode. They also check that a non-zero count only completes on a write cycle and that a session yields at most one event. The exact cycle of the event relative to the cause and the N-th write, and the rejection of wrong IDs and held trigger levels, can only be shown by the bench's scenarios. The same holds for the zero-count case and for discarding a partial count on disable, which the bench compares against its behavioural model.

// File: rtl/trig_evt_pkg.sv
package trig_evt_pkg;

   typedef enum logic [1:0] {
      MODE_CIRC   = 2'd0,
      MODE_SWFIFO = 2'd1,
      MODE_HWFIFO = 2'd2,
      MODE_RSVD   = 2'd3
   } cap_mode_e;

   typedef enum logic [1:0] {
      DET_IDLE  = 2'd0,
      DET_COUNT = 2'd1,
      DET_DONE  = 2'd2
   } det_state_e;

endpackage

// File: rtl/trig_edge_sync.sv
// Optional synchronizer followed by a rising-edge detector on the trigger pin.
module trig_edge_sync #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   output logic rise_o
);

   if (SYNC_STAGES < 0) begin : g_bad_stages
      $error("trig_edge_sync: SYNC_STAGES must not be negative");
   end

   logic lvl;
   logic lvl_q;

   if (SYNC_STAGES == 0) begin : g_direct
      assign lvl = trig_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr <= '0;
         end else begin
            sr[0] <= trig_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               sr[i] <= sr[i-1];
            end
         end
      end
      assign lvl = sr[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign rise_o = lvl & ~lvl_q;

endmodule

// File: rtl/trig_cause_detect.sv
// Merges the pin edge and the in-band trigger ID into a single cause strobe.
module trig_cause_detect #(
   parameter int              ID_W    = 7,
   parameter logic [ID_W-1:0] TRIG_ID = 7'h7D
) (
   input  logic            pin_rise,
   input  logic            beat_valid,
   input  logic [ID_W-1:0] beat_id,
   output logic            cause_o
);

   if (ID_W < 1) begin : g_bad_id
      $error("trig_cause_detect: ID_W must be at least 1");
   end

   logic id_hit;

   always_comb begin
      id_hit  = beat_valid && (beat_id == TRIG_ID);
      cause_o = pin_rise || id_hit;
   end

endmodule

// File: rtl/trig_word_counter.sv
// Arms on the first cause of a session and counts committed words to the target.
module trig_word_counter
   import trig_evt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             cause,
   input  logic             mem_wr,
   input  logic [CNT_W-1:0] target,
   output logic             event_o
);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("trig_word_counter: CNT_W must be at least 1");
   end

   det_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;
   logic             evt_q;

   assign cnt_inc = cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= DET_IDLE;
         cnt   <= '0;
         evt_q <= 1'b0;
      end else begin
         evt_q <= 1'b0;
         if (!active) begin
            st  <= DET_IDLE;
            cnt <= '0;
         end else begin
            unique case (st)
               DET_IDLE: begin
                  if (cause) begin
                     cnt <= '0;
                     if (target == '0) begin
                        evt_q <= 1'b1;
                        st    <= DET_DONE;
                     end else begin
                        st <= DET_COUNT;
                     end
                  end
               end
               DET_COUNT: begin
                  if (mem_wr) begin
                     cnt <= cnt_inc;
                     if (cnt_inc == target) begin
                        evt_q <= 1'b1;
                        st    <= DET_DONE;
                     end
                  end
               end
               DET_DONE: begin
                  st <= DET_DONE;
               end
               default: begin
                  st <= DET_IDLE;
               end
            endcase
         end
      end
   end

   assign event_o = evt_q;

endmodule

// File: rtl/trig_event_detect.sv
module trig_event_detect
   import trig_evt_pkg::*;
#(
   parameter int              CNT_W       = 16,
   parameter int              ID_W        = 7,
   parameter logic [ID_W-1:0] TRIG_ID     = 7'h7D,
   parameter int              SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capt_en,
   input  logic [1:0]       mode,
   input  logic             trig_in,
   input  logic             beat_valid,
   input  logic [ID_W-1:0]  beat_id,
   input  logic             mem_wr,
   input  logic [CNT_W-1:0] word_count,
   output logic             event_o
);

   logic pin_rise;
   logic cause;
   logic active;

   assign active = capt_en && (cap_mode_e'(mode) == MODE_CIRC);

   trig_edge_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_in(trig_in),
      .rise_o (pin_rise)
   );

   trig_cause_detect #(
      .ID_W   (ID_W),
      .TRIG_ID(TRIG_ID)
   ) u_cause (
      .pin_rise  (pin_rise),
      .beat_valid(beat_valid),
      .beat_id   (beat_id),
      .cause_o   (cause)
   );

   trig_word_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .cause  (cause),
      .mem_wr (mem_wr),
      .target (word_count),
      .event_o(event_o)
   );

endmodule

// File: rtl/trig_evt_chk.sv
module trig_evt_chk
   import trig_evt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             capt_en,
   input logic [1:0]       mode,
   input logic             mem_wr,
   input logic [CNT_W-1:0] word_count,
   input logic             event_o
);

   // Set once an event has been seen in the current capture session.
   logic fired_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fired_q <= 1'b0;
      else if (!capt_en) fired_q <= 1'b0;
      else if (event_o)  fired_q <= 1'b1;
   end

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |=> !event_o);

   a_r7_fifo_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd0) |=> !event_o);

   a_r10_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !capt_en |=> !event_o);

   a_r5_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (event_o && $past(word_count) != '0) |-> $past(mem_wr));

   a_r9_once_per_session: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |-> !fired_q);

endmodule

bind trig_event_detect trig_evt_chk #(
   .CNT_W(CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .capt_en   (capt_en),
   .mode      (mode),
   .mem_wr    (mem_wr),
   .word_count(word_count),
   .event_o   (event_o)
);

// File: tb/sim_trig_event_detect.sv
module sim_trig_event_detect;

   localparam int CLK_PERIOD = 10;
   localparam int CW         = 16;
   localparam int WATCHDOG   = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          capt_en = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic          trig_in = 1'b0;
   logic          beat_valid = 1'b0;
   logic [6:0]    beat_id = 7'h00;
   logic          mem_wr = 1'b0;
   logic [CW-1:0] word_count = '0;
   logic          event_o;

   int    checks = 0;
   int    fails  = 0;
   int    cyc    = 0;
   bit    done   = 1'b0;
   string cur_req = "R8";
   int    events_seen = 0;

   // Behavioural reference state
   int m_state = 0;  // 0 waiting for cause, 1 counting, 2 spent
   int m_cnt   = 0;
   bit m_prev  = 1'b0;
   bit exp_evt = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trig_event_detect #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .capt_en(capt_en), .mode(mode),
      .trig_in(trig_in), .beat_valid(beat_valid), .beat_id(beat_id),
      .mem_wr(mem_wr), .word_count(word_count), .event_o(event_o)
   );

   always @(posedge clk) begin
      bit act, rise, cz;
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_prev = 1'b0; exp_evt = 1'b0;
      end else begin
         act    = capt_en && (mode == 2'd0);
         rise   = trig_in && !m_prev;
         m_prev = trig_in;
         cz     = rise || (beat_valid && beat_id == 7'h7D);
         exp_evt = 1'b0;
         if (!act) begin
            m_state = 0; m_cnt = 0;
         end else if (m_state == 0) begin
            if (cz) begin
               m_cnt = 0;
               if (word_count == 0) begin exp_evt = 1'b1; m_state = 2; end
               else m_state = 1;
            end
         end else if (m_state == 1) begin
            if (mem_wr) begin
               m_cnt++;
               if (m_cnt == int'(word_count)) begin exp_evt = 1'b1; m_state = 2; end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (event_o !== exp_evt) begin
            fails++;
            $display("FAIL %s: cycle %0d event_o actual %b expected %b",
                     cur_req, cyc, event_o, exp_evt);
         end
         if (event_o === 1'b1) events_seen++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic writes(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         mem_wr = 1'b1; tick();
         mem_wr = 1'b0; tick(gap);
      end
   endtask

   task automatic pin_pulse();
      trig_in = 1'b1; tick();
      trig_in = 1'b0;
   endtask

   task automatic session_off();
      capt_en = 1'b0; tick(2);
   endtask

   task automatic expect_events(input string req, input int n);
      checks++;
      if (events_seen != n) begin
         fails++;
         $display("FAIL %s: event count actual %0d expected %0d", req, events_seen, n);
      end
      events_seen = 0;
   endtask

   initial begin
      // R8: reset state
      cur_req = "R8";
      tick(3);
      checks++;
      if (event_o !== 1'b0) begin
         fails++;
         $display("FAIL R8: event_o in reset actual %b expected 0", event_o);
      end
      rst_n = 1'b1;
      capt_en = 1'b1; mode = 2'd0; word_count = 16'd2;
      writes(3, 1);
      expect_events("R8", 0);

      // R1 and R3: pin edge, then three writes
      session_off();
      cur_req = "R1"; capt_en = 1'b1; word_count = 16'd3; tick();
      pin_pulse();
      cur_req = "R3"; writes(3, 0); tick(3);
      expect_events("R1", 1);

      // R2: wrong ID and invalid beats are not causes; then the real one
      session_off();
      cur_req = "R2"; capt_en = 1'b1; word_count = 16'd2; tick();
      beat_valid = 1'b1; beat_id = 7'h7C; tick();
      beat_valid = 1'b0; beat_id = 7'h7D; tick();
      writes(3, 0);
      expect_events("R2", 0);
      beat_valid = 1'b1; tick(); beat_valid = 1'b0;
      // R5: idle cycles between writes do not count
      cur_req = "R5"; tick(4); writes(1, 3); writes(1, 3);
      expect_events("R5", 1);

      // R3: write in the cause cycle is not counted
      session_off();
      cur_req = "R3"; capt_en = 1'b1; word_count = 16'd1; tick();
      trig_in = 1'b1; mem_wr = 1'b1; tick();
      trig_in = 1'b0; mem_wr = 1'b0; tick(2);
      expect_events("R3", 0);
      writes(1, 2);
      expect_events("R3", 1);

      // R4: zero count fires the cycle after the cause
      session_off();
      cur_req = "R4"; capt_en = 1'b1; word_count = 16'd0; tick();
      beat_valid = 1'b1; beat_id = 7'h7D; tick();
      beat_valid = 1'b0; tick(3);
      expect_events("R4", 1);

      // R9: second cause mid-count does not restart; nothing after the event
      session_off();
      cur_req = "R9"; capt_en = 1'b1; word_count = 16'd3; tick();
      pin_pulse(); writes(2, 0);
      pin_pulse(); writes(1, 0); tick(2);
      expect_events("R9", 1);
      pin_pulse(); beat_valid = 1'b1; tick(); beat_valid = 1'b0;
      writes(5, 0);
      expect_events("R9", 0);

      // R6: pulse width, long count
      session_off();
      cur_req = "R6"; capt_en = 1'b1; word_count = 16'd7; tick();
      pin_pulse(); writes(7, 1); tick(3);
      expect_events("R6", 1);

      // R7: FIFO and reserved modes stay silent
      for (int m = 1; m < 4; m++) begin
         session_off();
         cur_req = "R7"; mode = 2'(m); capt_en = 1'b1; word_count = 16'd0; tick();
         pin_pulse(); beat_valid = 1'b1; beat_id = 7'h7D; tick(); beat_valid = 1'b0;
         writes(3, 0);
         expect_events("R7", 0);
      end
      mode = 2'd0;

      // R1: level held high across enable is not an edge
      session_off();
      cur_req = "R1"; trig_in = 1'b1; tick(2);
      capt_en = 1'b1; word_count = 16'd0; tick(4);
      expect_events("R1", 0);
      trig_in = 1'b0; tick();

      // R10: disabling mid-count discards the partial count
      session_off();
      cur_req = "R10"; capt_en = 1'b1; word_count = 16'd2; tick();
      pin_pulse(); writes(1, 0);
      capt_en = 1'b0; tick(2); capt_en = 1'b1; tick();
      writes(4, 0);
      expect_events("R10", 0);
      pin_pulse(); writes(2, 0); tick(2);
      expect_events("R10", 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule